// File: doc/BRIEF.md
# Serial Byte Transmitter with Selectable Parity

This block turns a parallel byte into an asynchronous serial frame on one output line. The line rests high. A frame is a low start bit, the data bits with the least significant bit first, an optional parity bit, and a high stop bit. A divider inside the block sets the bit timing from the system clock. It rounds the ratio of the clock frequency to the baud rate. The defaults are a 50 MHz clock and 9600 baud, which gives 5208 cycles per bit. A build-time parameter sets the parity to none, even or odd.

The user places a byte on `data_i` and pulses `send_i` for one cycle. If the block is idle, it captures the byte and starts the frame on the next cycle. If a frame is already in progress, it keeps the byte in a single holding slot. When the current stop bit ends, the held byte's start bit follows with no idle time between them, so back-to-back bytes stream out. `busy_o` stays high from the first start bit until the line returns to idle.

Top module: `uart_serial_tx`

## Requirements
- R1: While `rst_ni` is low, `tx_o` is 1 and `busy_o` is 0. A reset in the middle of a frame returns the line to 1 at once.
- R2: A `send_i` pulse seen at a clock edge while idle starts the start bit (`tx_o` = 0) and raises `busy_o` in the cycle after that edge.
- R3: Every bit lasts exactly DIV clock cycles, where DIV = round(CLK_HZ / BAUD). The default is 5208.
- R4: The DATA_W data bits follow the start bit with bit 0 first.
- R5: In even mode (PAR_EVEN), one parity bit follows the data. It makes the number of ones in the data plus parity even. The frame is 11 bit periods long.
- R6: In odd mode (PAR_ODD), the parity bit makes that number of ones odd.
- R7: In no-parity mode (PAR_NONE), the stop bit follows the last data bit directly. The frame is 10 bit periods long.
- R8: The stop bit is 1. If nothing is waiting, `busy_o` falls at the end of the stop bit and `tx_o` stays 1.
- R9: A `send_i` pulse during a frame stores its byte if the holding slot is empty. That byte's start bit begins at the edge where the stop bit ends, and `busy_o` stays high across the boundary.
- R10: A `send_i` pulse during a frame while the holding slot is full has no effect. No extra frame appears on `tx_o`.
- R11: The byte is captured when the pulse is accepted. Changing `data_i` after that does not alter the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Byte to send |
| send_i | input | 1 | One-cycle request to send `data_i` |
| busy_o | output | 1 | High while a frame is on the line |
| tx_o | output | 1 | Serial output, high when idle |

## Verification
The assertions assume that `send_i` is a synchronous single-cycle pulse. They also assume that DIV is at least 2, so two baud ticks can never fall on adjacent cycles. The bench sets a 16-cycle bit time and changes inputs only on falling clock edges. It drops `send_i` after one cycle and changes `data_i` right after each pulse, which also tests byte capture. Pulses during a frame come a few cycles after a start. One of them fills the holding slot and the next is sent while the slot is still full.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {PAR_NONE, PAR_EVEN, PAR_ODD} parity_e;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP} tx_state_e;
endpackage

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned DIV = 5208
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  // counter is parked at zero while idle so each frame starts aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);

  assert_tick_isolated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tx_parity_bit.sv
module tx_parity_bit
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter parity_e     PARITY = PAR_EVEN
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              par_o
);
  generate
    if (PARITY == PAR_ODD) begin : g_odd
      assign par_o = ~(^data_i);
    end else if (PARITY == PAR_EVEN) begin : g_even
      assign par_o = ^data_i;
    end else begin : g_none
      assign par_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end else if (load_i && !valid_o) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end
  end

  assert_full_ignores_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && load_i && !take_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter parity_e     PARITY = PAR_EVEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              send_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              hold_valid_i,
  input  logic [DATA_W-1:0] hold_data_i,
  output logic              hold_load_o,
  output logic              hold_take_o,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int unsigned BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic HAS_PAR = (PARITY != PAR_NONE);

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] shift_q, next_byte;
  logic [BIT_W-1:0]  bit_q;
  logic              par_q, next_par;
  logic              stop_end, start_new;

  assign stop_end  = (state_q == ST_STOP) && tick_i;
  assign start_new = ((state_q == ST_IDLE) && send_i) ||
                     (stop_end && (hold_valid_i || send_i));
  // held byte wins over a fresh pulse at the frame boundary
  assign next_byte = hold_valid_i ? hold_data_i : data_i;

  assign hold_take_o = stop_end && hold_valid_i;
  assign hold_load_o = send_i && (state_q != ST_IDLE) && !stop_end;

  tx_parity_bit #(.DATA_W(DATA_W), .PARITY(PARITY)) u_par (
    .data_i (next_byte),
    .par_o  (next_par)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (send_i) state_d = ST_START;
      ST_START:  if (tick_i) state_d = ST_DATA;
      ST_DATA:   if (tick_i && bit_q == LAST_BIT) state_d = HAS_PAR ? ST_PARITY : ST_STOP;
      ST_PARITY: if (tick_i) state_d = ST_STOP;
      ST_STOP:   if (tick_i) state_d = start_new ? ST_START : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      bit_q   <= '0;
      par_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_new) begin
        shift_q <= next_byte;
        par_q   <= next_par;
        bit_q   <= '0;
      end else if (state_q == ST_DATA && tick_i) begin
        shift_q <= shift_q >> 1;
        bit_q   <= bit_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START:  tx_o = 1'b0;
      ST_DATA:   tx_o = shift_q[0];
      ST_PARITY: tx_o = par_q;
      default:   tx_o = 1'b1;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);

  assert_bit_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q != ST_IDLE) && !tick_i) |=> $stable(state_q));
  assert_chain_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_end && hold_valid_i) |=> (state_q == ST_START));
  assert_no_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !$past(hold_valid_i));
endmodule

// File: rtl/uart_serial_tx.sv
module uart_serial_tx
  import uart_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned BAUD   = 9600,
  parameter int unsigned DATA_W = 8,
  parameter parity_e     PARITY = PAR_EVEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              send_i,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int unsigned DIV = (CLK_HZ + BAUD / 2) / BAUD;

  logic              tick;
  logic              hold_valid, hold_load, hold_take;
  logic [DATA_W-1:0] hold_data;

  baud_tick_gen #(.DIV(DIV)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (hold_load),
    .data_i  (data_i),
    .take_i  (hold_take),
    .valid_o (hold_valid),
    .data_o  (hold_data)
  );

  tx_frame_fsm #(.DATA_W(DATA_W), .PARITY(PARITY)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .send_i       (send_i),
    .data_i       (data_i),
    .hold_valid_i (hold_valid),
    .hold_data_i  (hold_data),
    .hold_load_o  (hold_load),
    .hold_take_o  (hold_take),
    .busy_o       (busy_o),
    .tx_o         (tx_o)
  );

  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);
  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !tx_o);
  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && send_i) |=> busy_o);
endmodule

// File: tb/uart_serial_tx_test.sv
module uart_serial_tx_test;
  import uart_tx_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 16;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [7:0] b;
    logic       pe;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h00, 1'b0}, '{8'hFF, 1'b0}, '{8'h01, 1'b1}, '{8'h80, 1'b1},
    '{8'hA5, 1'b0}, '{8'h7F, 1'b1}, '{8'h3C, 1'b0}, '{8'hE0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       send_i = 1'b0;
  logic       busy_e, tx_e, busy_o_, tx_o_, busy_n, tx_n;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_serial_tx #(.CLK_HZ(DIV), .BAUD(1), .PARITY(PAR_EVEN)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .send_i(send_i), .busy_o(busy_e), .tx_o(tx_e));
  uart_serial_tx #(.CLK_HZ(DIV), .BAUD(1), .PARITY(PAR_ODD)) uut_odd (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .send_i(send_i), .busy_o(busy_o_), .tx_o(tx_o_));
  uart_serial_tx #(.CLK_HZ(DIV), .BAUD(1), .PARITY(PAR_NONE)) uut_none (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .send_i(send_i), .busy_o(busy_n), .tx_o(tx_n));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected line value at bit position k of a frame
  function automatic logic exp_bit(input logic [7:0] b, input logic par, input int k, input bit has_par);
    if (k == 0) return 1'b0;
    if (k <= 8) return b[k-1];
    if (k == 9) return has_par ? par : 1'b1;
    return 1'b1;
  endfunction

  // leaves the bench half a cycle after the accepting edge
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    data_i = b;
    send_i = 1'b1;
    @(negedge clk);
    send_i = 1'b0;
    data_i = ~b;
  endtask

  task automatic check_frames(input logic [7:0] b, input logic pe);
    repeat (DIV / 2) @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      chk((k == 0) ? "R2 even" : (k <= 8) ? "R4 R11 even" : (k == 9) ? "R5 even" : "R8 even",
          tx_e, exp_bit(b, pe, k, 1'b1));
      chk((k == 9) ? "R6 odd" : "R4 odd", tx_o_, exp_bit(b, ~pe, k, 1'b1));
      chk((k >= 9) ? "R7 none" : "R4 none", tx_n, exp_bit(b, 1'b0, k, 1'b0));
      if (k == 10) chk("R7 none ended", busy_n, 1'b0);
      if (k < 10) repeat (DIV) @(negedge clk);
    end
    repeat (DIV / 2) @(negedge clk);
    chk("R8 even idle", {busy_e, tx_e}, 2'b01);
    chk("R8 odd idle", {busy_o_, tx_o_}, 2'b01);
  endtask

  initial begin
    #1;
    chk("R1 reset", {busy_e, tx_e}, 2'b01);
    repeat (3) @(negedge clk);
    chk("R1 in reset", {busy_n, tx_n, busy_o_, tx_o_}, 4'b0101);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", {busy_e, tx_e}, 2'b01);

    foreach (VECS[i]) begin
      send_byte(VECS[i].b);
      check_frames(VECS[i].b, VECS[i].pe);
    end

    // R3: exact bit length and frame end
    send_byte(8'h01);
    chk("R2 busy", busy_e, 1'b1);
    repeat (DIV - 1) @(negedge clk);
    chk("R3 start last cycle", tx_e, 1'b0);
    @(negedge clk);
    chk("R3 bit0 first cycle", tx_e, 1'b1);
    repeat (10 * DIV - 1) @(negedge clk);
    chk("R3 last cycle busy", busy_e, 1'b1);
    @(negedge clk);
    chk("R3 R8 busy falls", {busy_e, tx_e}, 2'b01);

    // R9/R10: queued byte chains, third pulse dropped
    begin
      logic [7:0] a = 8'h5A;
      logic [7:0] b = 8'hC3;
      send_byte(a);
      send_byte(b);
      send_byte(8'hFF);
      repeat (DIV / 2 - 4) @(negedge clk);
      for (int k = 0; k < 22; k++) begin
        if (k < 11) chk("R9 frame A", tx_e, exp_bit(a, ^a, k, 1'b1));
        else chk("R9 frame B", tx_e, exp_bit(b, ^b, k - 11, 1'b1));
        if (k == 10 || k == 11) chk("R9 busy held", busy_e, 1'b1);
        if (k < 21) repeat (DIV) @(negedge clk);
      end
      repeat (DIV / 2) @(negedge clk);
      chk("R9 end idle", busy_e, 1'b0);
      begin
        int lows = 0;
        for (int c = 0; c < 12 * DIV; c++) begin
          @(negedge clk);
          if (!tx_e || busy_e) lows++;
        end
        chk("R10 dropped pulse", 8'(lows), 8'd0);
      end
    end

    // R1: reset in mid-frame
    send_byte(8'h00);
    repeat (3 * DIV) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 mid-frame reset", {busy_e, tx_e, busy_n, tx_n}, 4'b0101);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {busy_e, tx_e}, 2'b01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule